// File: doc/BRIEF.md
# Configuration Strap Sampler and Status Indicator Driver

This block controls five shared pads on a network transceiver. Each pad first acts as a configuration strap and then as a status indicator output. While the hardware reset is held, every pad is an input and its driver stays off. On the first clock edge after reset is released, the pad levels are captured into flops that only a hardware reset can clear. Together they form a 5-bit management address, with pad i giving address bit i.

After the capture, each pad is an output that shows one selectable status condition. The possible conditions are:
- link up
- activity
- transmit
- receive
- collision
- speed
- duplex
- off

The polarity of each pad follows its own captured strap level. A pad that was pulled low drives high when its condition is active, and the reverse. This lets an indicator wired in series with the strap resistor light up.

Short activity, transmit and receive events are stretched so that an indicator can show them. A software reset returns the selects and the stretchers to their defaults. It leaves the straps, the address and the pad direction alone.

Top module: `strap_led_ctrl`

## Requirements
- R1: While `hw_rst_n` is low, every bit of `pad_oe` is 0, combinationally, with no clock edge needed.
- R2: At the first rising clock edge where `hw_rst_n` is high, each `pad_in[i]` is captured and `mgmt_addr[i]` shows it from then on. For example, pads 0 and 4 high with pads 1 to 3 low give address 17.
- R3: Captured straps and `mgmt_addr` do not follow later changes on `pad_in` until the next hardware reset.
- R4: From the cycle after the capture edge, every bit of `pad_oe` is 1 for as long as `hw_rst_n` stays high.
- R5: While `sw_rst_n` is low, three things stay as they are: `mgmt_addr`, `pad_oe` (all ones) and the straps. Every pad drives its inactive level. A rising clock edge with `sw_rst_n` low restores the default selects and clears the stretchers.
- R6: Once enabled, `pad_out[i]` equals the captured strap bit when its status is inactive, and the inverse of that bit when its status is active.
- R7: The 3-bit select code of each pad picks its status source:
  - 0: link
  - 1: activity
  - 2: transmit
  - 3: receive
  - 4: collision
  - 5: speed
  - 6: duplex
  - 7: always inactive
- R8: After either reset, the select codes are:
  - pad 0: link (0)
  - pad 1: activity (1)
  - pad 2: transmit (2)
  - pad 3: receive (3)
  - pad 4: duplex (6)
- R9: An activity, transmit or receive input sampled high at a rising edge keeps its status active for STRETCH_CYC (default 16) further clock cycles after that edge.
- R10: When `cfg_we` is high at a rising edge, `cfg_sel` is loaded, with bits [3i+2:3i] holding the select code for pad i. The new selection applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hw_rst_n | input | 1 | Hardware/power-on reset, active low, synchronous to clk |
| sw_rst_n | input | 1 | Software reset, active low, synchronous |
| pad_in | input | 5 | Level seen at each pad |
| pad_out | output | 5 | Value driven onto each pad |
| pad_oe | output | 5 | Pad driver enable, one per pad |
| mgmt_addr | output | 5 | Management address from captured straps |
| cfg_we | input | 1 | Select register write strobe |
| cfg_sel | input | 15 | New select codes, 3 bits per pad |
| st_link | input | 1 | Link up condition |
| st_act | input | 1 | Activity event |
| st_tx | input | 1 | Transmit event |
| st_rx | input | 1 | Receive event |
| st_col | input | 1 | Collision condition |
| st_speed | input | 1 | Speed mode condition |
| st_duplex | input | 1 | Duplex condition |

## Verification
The bench sweeps all 32 strap patterns through a hardware reset. For each one it checks the following:
- The pads stay undriven during sampling.
- The address matches the pattern.
- The address ignores pad changes after capture.
- Every pad drives its strap level when idle and the inverse when active.

A design that captured one cycle late, or that used a single global polarity, would fail on the asymmetric patterns. The bench also selects each source code on all pads in turn, including the off code. It then pulses activity for a single cycle and counts exactly how many cycles the pad stays lit, which catches a stretcher that is off by one. Finally it holds a software reset and checks that neither the address nor the driver enables move. A design that tied the strap flops to the software reset would lose the address there.

// File: rtl/strap_pkg.sv
// Package: shared select-code encoding for the strap/indicator controller.
// Assumes: 3-bit select field per pad; code 7 means "never active".
package strap_pkg;
    localparam int SEL_W = 3;
    localparam int NUM_SRC = 7;

    typedef enum logic [SEL_W-1:0] {
        SRC_LINK   = 3'd0,
        SRC_ACT    = 3'd1,
        SRC_TX     = 3'd2,
        SRC_RX     = 3'd3,
        SRC_COL    = 3'd4,
        SRC_SPEED  = 3'd5,
        SRC_DUPLEX = 3'd6,
        SRC_OFF    = 3'd7
    } led_src_e;
endpackage

// File: rtl/strap_capture.sv
// Module: strap_capture
// Latches the pad levels once, on the first rising edge where the hardware
// reset is inactive, and raises a done flag. Only hw_rst_n clears it.
// Assumes: hw_rst_n is already synchronized to clk.
module strap_capture #(
    parameter int NUM_PADS = 5
) (
    input  logic                clk,
    input  logic                hw_rst_n,
    input  logic [NUM_PADS-1:0] pad_in,
    output logic [NUM_PADS-1:0] strap_q,
    output logic                done_q
);

    // Capture straps once after hardware reset release, then hold.
    always_ff @(posedge clk) begin
        if (!hw_rst_n) begin
            strap_q <= '0;
            done_q  <= 1'b0;
        end else if (!done_q) begin
            strap_q <= pad_in;
            done_q  <= 1'b1;
        end
    end

    AST_CAPTURE_FROM_PAD: assert property (@(posedge clk) disable iff (!hw_rst_n)
        $rose(done_q) |-> strap_q == $past(pad_in)); // R2

    AST_STRAP_HOLD: assert property (@(posedge clk) disable iff (!hw_rst_n)
        ($past(done_q) && $past(hw_rst_n)) |-> $stable(strap_q)); // R3

endmodule

// File: rtl/pulse_stretch.sv
// Module: pulse_stretch
// Holds a short event active for STRETCH_CYC cycles after its last sampled
// high, so that a brief event stays visible on an indicator.
// Assumes: rst_n is synchronous and active low; STRETCH_CYC >= 1.
module pulse_stretch #(
    parameter int STRETCH_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse_in,
    output logic held_out
);
    localparam int CW = $clog2(STRETCH_CYC + 1);

    logic [CW-1:0] cnt_q;

    // Reload on each event, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (pulse_in)
            cnt_q <= CW'(STRETCH_CYC);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    // Output is the live event or any remaining hold time.
    always_comb held_out = pulse_in | (cnt_q != '0);

    AST_STRETCH_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(pulse_in) && $past(rst_n)) |-> held_out); // R9

endmodule

// File: rtl/led_src_mux.sv
// Module: led_src_mux
// Selects one status condition for a pad from its 3-bit select code.
// Assumes: src bit order matches the led_src_e code values 0..6.
module led_src_mux
    import strap_pkg::*;
(
    input  logic [SEL_W-1:0]   sel,
    input  logic [NUM_SRC-1:0] src,
    output logic               led_on
);
    // Decode the select code; the off code is never active.
    always_comb begin
        unique case (led_src_e'(sel))
            SRC_LINK:   led_on = src[0];
            SRC_ACT:    led_on = src[1];
            SRC_TX:     led_on = src[2];
            SRC_RX:     led_on = src[3];
            SRC_COL:    led_on = src[4];
            SRC_SPEED:  led_on = src[5];
            SRC_DUPLEX: led_on = src[6];
            default:    led_on = 1'b0;
        endcase
    end
endmodule

// File: rtl/strap_led_ctrl.sv
// Module: strap_led_ctrl (top)
// Owns the shared strap/indicator pads. It samples the straps at hardware
// reset exit, then enables the drivers and shows each pad's selected status
// with a polarity opposite to its own strap level.
// Assumes: both resets are synchronous to clk and active low.
module strap_led_ctrl
    import strap_pkg::*;
#(
    parameter int NUM_PADS    = 5,
    parameter int STRETCH_CYC = 16,
    parameter logic [NUM_PADS*SEL_W-1:0] DEF_SEL = {3'd6, 3'd3, 3'd2, 3'd1, 3'd0}
) (
    input  logic                      clk,
    input  logic                      hw_rst_n,
    input  logic                      sw_rst_n,
    input  logic [NUM_PADS-1:0]       pad_in,
    output logic [NUM_PADS-1:0]       pad_out,
    output logic [NUM_PADS-1:0]       pad_oe,
    output logic [NUM_PADS-1:0]       mgmt_addr,
    input  logic                      cfg_we,
    input  logic [NUM_PADS*SEL_W-1:0] cfg_sel,
    input  logic                      st_link,
    input  logic                      st_act,
    input  logic                      st_tx,
    input  logic                      st_rx,
    input  logic                      st_col,
    input  logic                      st_speed,
    input  logic                      st_duplex
);
    localparam int NUM_STRETCH = 3;

    logic [NUM_PADS-1:0]       strap_q;
    logic                      done_q;
    logic [NUM_PADS*SEL_W-1:0] sel_q;
    logic                      ctl_rst_n;
    logic [NUM_STRETCH-1:0]    raw_evt;
    logic [NUM_STRETCH-1:0]    held_evt;
    logic [NUM_SRC-1:0]        src;
    logic [NUM_PADS-1:0]       led_on;
    logic [NUM_PADS-1:0]       active;

    strap_capture #(.NUM_PADS(NUM_PADS)) u_cap (
        .clk      (clk),
        .hw_rst_n (hw_rst_n),
        .pad_in   (pad_in),
        .strap_q  (strap_q),
        .done_q   (done_q)
    );

    // Either reset returns the control state to its defaults.
    always_comb ctl_rst_n = hw_rst_n & sw_rst_n;

    // Select register: reset to defaults, loaded by write strobe.
    always_ff @(posedge clk) begin
        if (!ctl_rst_n)
            sel_q <= DEF_SEL;
        else if (cfg_we)
            sel_q <= cfg_sel;
    end

    // Group the events that need stretching.
    always_comb raw_evt = {st_rx, st_tx, st_act};

    for (genvar s = 0; s < NUM_STRETCH; s++) begin : g_str
        pulse_stretch #(.STRETCH_CYC(STRETCH_CYC)) u_str (
            .clk      (clk),
            .rst_n    (ctl_rst_n),
            .pulse_in (raw_evt[s]),
            .held_out (held_evt[s])
        );
    end

    // Source vector ordered by select code.
    always_comb src = {st_duplex, st_speed, st_col, held_evt[2], held_evt[1], held_evt[0], st_link};

    for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
        led_src_mux u_mux (
            .sel    (sel_q[p*SEL_W +: SEL_W]),
            .src    (src),
            .led_on (led_on[p])
        );
    end

    // Software reset forces every indicator inactive.
    always_comb active = led_on & {NUM_PADS{sw_rst_n}};

    // Drivers only after capture and never during hardware reset.
    always_comb pad_oe = {NUM_PADS{hw_rst_n & done_q}};

    // Per-pad polarity: asserted level is the inverse of the strap.
    always_comb pad_out = strap_q ^ active;

    always_comb mgmt_addr = strap_q;

    AST_OE_AFTER_CAPTURE: assert property (@(posedge clk) disable iff (!hw_rst_n)
        $past(hw_rst_n) |-> &pad_oe); // R4

    AST_SWRST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!hw_rst_n)
        (!sw_rst_n && $past(hw_rst_n)) |-> (pad_out == mgmt_addr && &pad_oe)); // R5

    AST_NO_DRIVE_IN_RESET: assert property (@(posedge clk)
        !hw_rst_n |-> pad_oe == '0); // R1

endmodule

// File: tb/sim_strap_led_ctrl.sv
module sim_strap_led_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 5;
    localparam int SC = 16;

    logic clk = 1'b0;
    logic hw_rst_n = 1'b0;
    logic sw_rst_n = 1'b1;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pad_out, pad_oe, mgmt_addr;
    logic cfg_we = 1'b0;
    logic [NP*3-1:0] cfg_sel = '0;
    logic [6:0] st = '0;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    strap_led_ctrl u0 (
        .clk(clk), .hw_rst_n(hw_rst_n), .sw_rst_n(sw_rst_n),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .mgmt_addr(mgmt_addr), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .st_link(st[0]), .st_act(st[1]), .st_tx(st[2]), .st_rx(st[3]),
        .st_col(st[4]), .st_speed(st[5]), .st_duplex(st[6])
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic hw_reset(input logic [NP-1:0] p);
        @(negedge clk);
        st = '0;
        hw_rst_n = 1'b0;
        pad_in = p;
        @(negedge clk);
        #1;
        chk(pad_oe == '0, "R1 oe off in reset", pad_oe, 0);
        hw_rst_n = 1'b1;
        @(negedge clk);
        #1;
    endtask

    task automatic write_all(input logic [2:0] code);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_sel = {NP{code}};
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic sw_pulse();
        @(negedge clk);
        sw_rst_n = 1'b0;
        @(negedge clk);
        sw_rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        // R2 R3 R4 R6: sweep all 32 strap patterns
        for (int p = 0; p < 32; p++) begin
            hw_reset(NP'(p));
            chk(mgmt_addr == NP'(p), "R2 address capture", mgmt_addr, p);
            chk(pad_oe == '1, "R4 outputs enabled", pad_oe, 31);
            pad_in = ~NP'(p);
            @(negedge clk);
            #1;
            chk(mgmt_addr == NP'(p), "R3 strap held", mgmt_addr, p);
            chk(pad_out == NP'(p), "R6 idle level = strap", pad_out, p);
            st = 7'b1001111;
            #1;
            chk(pad_out == ~NP'(p), "R6 active level inverted", pad_out, 31 - p);
        end

        // R8: default selects, straps = 17
        hw_reset(NP'(17));
        chk(mgmt_addr == 5'd17, "R2 address 17", mgmt_addr, 17);
        st = 7'b0000001; #1;
        chk(pad_out == 5'd16, "R8 pad0 link", pad_out, 16);
        st = 7'b1000000; #1;
        chk(pad_out == 5'd1, "R8 pad4 duplex", pad_out, 1);
        st = 7'b0110000; #1;
        chk(pad_out == 5'd17, "R8 col/speed unused", pad_out, 17);
        st = 7'b0000100; #1;
        chk(pad_out == 5'd21, "R8 pad2 tx", pad_out, 21);

        // R7 R10: every select code on all pads
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            st = '0;
            sw_pulse();
            write_all(3'(k));
            st = '1;
            #1;
            chk(pad_out == ((k < 7) ? 5'd14 : 5'd17), "R7 R10 code all-on", pad_out, (k < 7) ? 14 : 17);
            st = '1;
            if (k < 7) st[k] = 1'b0;
            @(negedge clk);
            #1;
            if (k == 0 || k > 3)
                chk(pad_out == 5'd17, "R7 only selected source", pad_out, 17);
        end

        // R9: single-cycle activity pulse, stretched
        @(negedge clk);
        st = '0;
        sw_pulse();
        write_all(3'd1);
        st[1] = 1'b1;
        @(negedge clk);
        st[1] = 1'b0;
        for (int j = 0; j <= SC; j++) begin
            #1;
            chk(pad_out == ((j < SC) ? 5'd14 : 5'd17), "R9 stretch window", pad_out, (j < SC) ? 14 : 17);
            @(negedge clk);
        end

        // R5: software reset keeps straps and direction
        write_all(3'd6);
        st[6] = 1'b1;
        #1;
        chk(pad_out == 5'd14, "R5 pre sw reset active", pad_out, 14);
        sw_rst_n = 1'b0;
        #1;
        chk(pad_out == 5'd17, "R5 idle during sw reset", pad_out, 17);
        @(negedge clk);
        #1;
        chk(pad_oe == '1, "R5 oe kept", pad_oe, 31);
        chk(mgmt_addr == 5'd17, "R5 address kept", mgmt_addr, 17);
        sw_rst_n = 1'b1;
        #1;
        chk(pad_out == 5'd1, "R5 R8 defaults after sw reset", pad_out, 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule